// File: doc/BRIEF.md
# Eight-Digit Display Host Register File

This block is the host-facing write port and the storage of an eight-digit dot-matrix display controller. A processor drives one 8-bit data bus, a 4-bit address, an active-low chip enable, an active-low write strobe and an active-low flash select. The block steers each write to exactly one of three stores. These are a character memory of eight 8-bit words, a set of eight one-bit blink flags (one per digit), and a single 8-bit control word.

The character word holds a 7-bit character code in bits 6..0 and a font-page bit in bit 7. The scan logic of the controller picks a digit number. From that number it reads the character code, the page bit and the blink flag of the digit, and it also reads the control word. All of these reads are combinational. A synchronous reset makes every digit show a space, clears all blink flags and zeroes the control word.

Top module: `disp_regfile`

## Requirements
- R1: While `rst` is high at a rising clock edge, every character word becomes 0x20 (code 0x20, page 0), every blink flag becomes 0 and the control word becomes 0x00.
- R2: A write with `flash_sel_n`=1 and `bus_addr[3]`=1 stores `bus_data` into the character word of digit `bus_addr[2:0]`. Bits 6..0 appear on `scan_code` and bit 7 appears on `scan_page`.
- R3: A write with `flash_sel_n`=1 and `bus_addr[3]`=0 loads `bus_data` into the control word shown on `ctrl_word`.
- R4: A write with `flash_sel_n`=0 sets the blink flag of digit `bus_addr[2:0]` to `bus_data[0]`, whatever the value of `bus_addr[3]`. It changes no character word and does not change the control word.
- R5: No store changes in a cycle unless `ce_n` and `wr_n` are both 0 at that clock edge.
- R6: Reset takes priority over a write that is presented in the same cycle.
- R7: `scan_code`, `scan_page` and `scan_blink` follow `scan_digit` combinationally. A write to one digit leaves every other digit unchanged.
- R8: A write becomes visible only after the rising edge that ends the strobe cycle. Each cycle with the strobe active performs one write, and the data present in that cycle is the data stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_data | input | 8 | Host write data |
| bus_addr | input | 4 | Bit 3 selects character (1) or control (0); bits 2..0 select the digit |
| ce_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| flash_sel_n | input | 1 | Low steers the write to the blink flags |
| scan_digit | input | 3 | Digit index from the scan logic |
| scan_code | output | 7 | Character code of the selected digit |
| scan_page | output | 1 | Font page bit of the selected digit |
| scan_blink | output | 1 | Blink flag of the selected digit |
| ctrl_word | output | 8 | Control word |

## Verification
The hardest situation to reach is a flash-select write that also carries the character-mode address bit and a data pattern that would be a valid character. A faulty decoder would then corrupt a character word, or the control word, without any other sign. The stimulus sends such writes with both settings of address bit 3. Afterwards it scans all eight digits and the control word, so a stray update shows up anywhere. A write presented in the same cycle as reset, and a strobe held for two cycles with data that changes between them, cover the priority and the one-write-per-cycle ordering.

// File: rtl/disp_regs_pkg.sv
package disp_regs_pkg;

    localparam int unsigned DISP_DIGITS = 8;
    localparam int unsigned DISP_DATA_W = 8;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_CHAR  = 2'd1,
        TGT_CTRL  = 2'd2,
        TGT_FLASH = 2'd3
    } wr_target_e;

endpackage

// File: rtl/disp_wr_decode.sv
module disp_wr_decode
    import disp_regs_pkg::*;
#(
    parameter int unsigned DIGITS = DISP_DIGITS,
    parameter int unsigned DATA_W = DISP_DATA_W,
    localparam int unsigned IDX_W  = $clog2(DIGITS),
    localparam int unsigned ADDR_W = IDX_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              ce_n,
    input  logic              wr_n,
    input  logic              flash_sel_n,
    output wr_target_e        tgt,
    output logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] wdata
);

    logic strobe;

    always_comb begin
        strobe = ~ce_n & ~wr_n;
        idx    = addr[IDX_W-1:0];
        wdata  = data;
        if (!strobe) begin
            tgt = TGT_NONE;
        end else if (!flash_sel_n) begin
            tgt = TGT_FLASH;
        end else if (addr[ADDR_W-1]) begin
            tgt = TGT_CHAR;
        end else begin
            tgt = TGT_CTRL;
        end
    end

endmodule

// File: rtl/disp_char_mem.sv
module disp_char_mem #(
    parameter int unsigned DIGITS = 8,
    parameter int unsigned DATA_W = 8,
    parameter logic [DATA_W-1:0] BLANK_CODE = 'h20,
    localparam int unsigned IDX_W = $clog2(DIGITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DIGITS-1:0][DATA_W-1:0] word;
    } char_state_t;

    char_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < DIGITS; i++) begin
            if (rst) begin
                state_d.word[i] = BLANK_CODE;
            end else if (we && (widx == IDX_W'(i))) begin
                state_d.word[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign rdata = state_q.word[ridx];

    AST_CHAR_LOAD: assert property (@(posedge clk) disable iff (rst)
        we |=> state_q.word[$past(widx)] == $past(wdata)); // R2

endmodule

// File: rtl/disp_flash_mem.sv
module disp_flash_mem #(
    parameter int unsigned DIGITS = 8,
    localparam int unsigned IDX_W = $clog2(DIGITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic             wbit,
    input  logic [IDX_W-1:0] ridx,
    output logic             rbit
);

    typedef struct packed {
        logic [DIGITS-1:0] blink;
    } flash_state_t;

    flash_state_t      state_d, state_q;
    logic [DIGITS-1:0] hit;

    for (genvar g = 0; g < DIGITS; g++) begin : g_hit
        assign hit[g] = we && (widx == IDX_W'(g));
    end

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.blink = '0;
        end else begin
            for (int i = 0; i < DIGITS; i++) begin
                if (hit[i]) begin
                    state_d.blink[i] = wbit;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign rbit = state_q.blink[ridx];

    AST_FLASH_LOAD: assert property (@(posedge clk) disable iff (rst)
        we |=> state_q.blink[$past(widx)] == $past(wbit)); // R4

endmodule

// File: rtl/disp_ctrl_reg.sv
module disp_ctrl_reg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value
);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
    } ctrl_state_t;

    ctrl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.ctrl = '0;
        end else if (we) begin
            state_d.ctrl = wdata;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign value = state_q.ctrl;

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
        we |=> value == $past(wdata)); // R3

endmodule

// File: rtl/disp_regfile.sv
module disp_regfile
    import disp_regs_pkg::*;
#(
    parameter int unsigned DIGITS = DISP_DIGITS,
    parameter int unsigned DATA_W = DISP_DATA_W,
    parameter logic [DATA_W-1:0] BLANK_CODE = 'h20,
    localparam int unsigned IDX_W  = $clog2(DIGITS),
    localparam int unsigned ADDR_W = IDX_W + 1,
    localparam int unsigned CODE_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              ce_n,
    input  logic              wr_n,
    input  logic              flash_sel_n,
    input  logic [IDX_W-1:0]  scan_digit,
    output logic [CODE_W-1:0] scan_code,
    output logic              scan_page,
    output logic              scan_blink,
    output logic [DATA_W-1:0] ctrl_word
);

    wr_target_e        tgt;
    logic [IDX_W-1:0]  widx;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] char_word;

    disp_wr_decode #(.DIGITS(DIGITS), .DATA_W(DATA_W)) i_decode (
        .addr        (bus_addr),
        .data        (bus_data),
        .ce_n        (ce_n),
        .wr_n        (wr_n),
        .flash_sel_n (flash_sel_n),
        .tgt         (tgt),
        .idx         (widx),
        .wdata       (wdata)
    );

    disp_char_mem #(.DIGITS(DIGITS), .DATA_W(DATA_W), .BLANK_CODE(BLANK_CODE)) i_char (
        .clk   (clk),
        .rst   (rst),
        .we    (tgt == TGT_CHAR),
        .widx  (widx),
        .wdata (wdata),
        .ridx  (scan_digit),
        .rdata (char_word)
    );

    disp_flash_mem #(.DIGITS(DIGITS)) i_flash (
        .clk  (clk),
        .rst  (rst),
        .we   (tgt == TGT_FLASH),
        .widx (widx),
        .wbit (wdata[0]),
        .ridx (scan_digit),
        .rbit (scan_blink)
    );

    disp_ctrl_reg #(.DATA_W(DATA_W)) i_ctrl (
        .clk   (clk),
        .rst   (rst),
        .we    (tgt == TGT_CTRL),
        .wdata (wdata),
        .value (ctrl_word)
    );

    assign scan_code = char_word[CODE_W-1:0];
    assign scan_page = char_word[DATA_W-1];

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ce_n || wr_n) |=> $stable(ctrl_word)); // R5

    AST_FLASH_SPARES_CTRL: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !wr_n && !flash_sel_n) |=> $stable(ctrl_word)); // R4

endmodule

// File: tb/test_disp_regfile.sv
`timescale 1ns/1ps
module test_disp_regfile;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_data = '0;
    logic [3:0] bus_addr = '0;
    logic       ce_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       flash_sel_n = 1'b1;
    logic [2:0] scan_digit = '0;
    logic [6:0] scan_code;
    logic       scan_page;
    logic       scan_blink;
    logic [7:0] ctrl_word;

    always #2.5 clk = ~clk;

    disp_regfile i_disp_regfile (
        .clk(clk), .rst(rst), .bus_data(bus_data), .bus_addr(bus_addr),
        .ce_n(ce_n), .wr_n(wr_n), .flash_sel_n(flash_sel_n),
        .scan_digit(scan_digit), .scan_code(scan_code), .scan_page(scan_page),
        .scan_blink(scan_blink), .ctrl_word(ctrl_word)
    );

    typedef struct {
        logic [2:0] digit;
        logic [7:0] word;
        logic       blink;
        logic [7:0] ctrl;
        string      tag;
    } exp_t;

    exp_t       q[$];
    int         pending = 0;
    int         checks = 0;
    int         fails = 0;
    logic [7:0] m_char [8];
    logic       m_blink [8];
    logic [7:0] m_ctrl;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items and compares the scan outputs
    initial begin
        forever begin
            @(posedge clk);
            #0.5;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                scan_digit = e.digit;
                #0.2;
                chk({e.tag, " code"}, 32'(scan_code), 32'(e.word[6:0]));
                chk({e.tag, " page"}, 32'(scan_page), 32'(e.word[7]));
                chk({e.tag, " blink"}, 32'(scan_blink), 32'(e.blink));
                chk({e.tag, " ctrl"}, 32'(ctrl_word), 32'(e.ctrl));
                pending--;
            end
        end
    end

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_char[i] = 8'h20;
            m_blink[i] = 1'b0;
        end
        m_ctrl = 8'h00;
    endtask

    task automatic model_write(logic ce, logic wr, logic fl, logic [3:0] a, logic [7:0] d);
        if (!ce && !wr) begin
            if (!fl) m_blink[a[2:0]] = d[0];
            else if (a[3]) m_char[a[2:0]] = d;
            else m_ctrl = d;
        end
    endtask

    task automatic expect_all(string tag);
        for (int i = 0; i < 8; i++) begin
            exp_t e;
            e.digit = 3'(i);
            e.word = m_char[i];
            e.blink = m_blink[i];
            e.ctrl = m_ctrl;
            e.tag = tag;
            pending++;
            q.push_back(e);
        end
        wait (pending == 0);
        @(negedge clk);
    endtask

    // driver: one bus cycle, set at negedge, captured at the next posedge
    task automatic bus(logic ce, logic wr, logic fl, logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        ce_n = ce; wr_n = wr; flash_sel_n = fl; bus_addr = a; bus_data = d;
        model_write(ce, wr, fl, a, d);
        @(negedge clk);
        ce_n = 1'b1; wr_n = 1'b1; flash_sel_n = 1'b1;
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_all("R1 reset state");

        bus(0, 0, 1, 4'b1000, 8'h41);
        bus(0, 0, 1, 4'b1111, 8'hC5);
        bus(0, 0, 1, 4'b1011, 8'h7F);
        expect_all("R2 char writes");

        bus(0, 0, 1, 4'b0010, 8'hA5);
        expect_all("R3 ctrl write");

        bus(0, 0, 0, 4'b0011, 8'hFF);
        bus(0, 0, 0, 4'b1111, 8'h81);
        bus(0, 0, 0, 4'b0000, 8'h01);
        expect_all("R4 flash set");
        bus(0, 0, 0, 4'b1111, 8'hFE);
        expect_all("R4 flash clear");

        bus(1, 0, 1, 4'b1001, 8'h55);
        bus(0, 1, 1, 4'b0000, 8'h66);
        bus(1, 1, 0, 4'b0101, 8'h01);
        expect_all("R5 no strobe");

        for (int i = 0; i < 8; i++) bus(0, 0, 1, {1'b1, 3'(i)}, 8'(8'h30 + i));
        expect_all("R7 per digit");

        // R8: strobe cycle before the edge shows old data, then held for two cycles
        @(negedge clk);
        scan_digit = 3'd6;
        ce_n = 0; wr_n = 0; flash_sel_n = 1; bus_addr = 4'b1110; bus_data = 8'h99;
        #0.5;
        chk("R8 before edge", 32'({scan_page, scan_code}), 32'(m_char[6]));
        @(negedge clk);
        chk("R8 first cycle", 32'({scan_page, scan_code}), 32'h99);
        bus_data = 8'h5A;
        @(negedge clk);
        ce_n = 1; wr_n = 1;
        m_char[6] = 8'h5A;
        expect_all("R8 held strobe");

        // R6: reset with a write in the same cycle
        @(negedge clk);
        rst = 1; ce_n = 0; wr_n = 0; flash_sel_n = 1; bus_addr = 4'b0000; bus_data = 8'hEE;
        @(negedge clk);
        rst = 0; ce_n = 1; wr_n = 1;
        model_reset();
        expect_all("R6 reset priority");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule